// File: doc/BRIEF.md
# Serial-Bus Byte Store Slave with Page Buffer

This block is the slave side of a two-wire serial bus in front of a 2048 x 8 byte store. It runs on the system clock and synchronises the bus clock and data lines into that domain. It finds START and STOP conditions on the bus. It accepts one slave byte, whose top four bits select the device and whose next three bits carry the high memory address bits. It supports single-byte and multi-byte page writes, current-address reads, random reads and sequential reads. Its only bus output is an open-drain pull-down enable for the data line.

Page writes collect up to sixteen bytes in a local buffer. The buffer goes to the store only when a STOP closes the write. The copy then runs as a self-timed write cycle of `WR_CYCLES` clocks. During that cycle the slave ignores its own address, so a host can poll for the end of the cycle by repeating the slave byte. A write-protect input and a reset-inhibit input can each withhold the acknowledge and so block access.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: A START is a falling data line while the clock line is high, and a STOP is a rising data line while the clock line is high. A START or STOP that arrives in the middle of a byte abandons the transfer, and a write cut off this way changes no memory byte.
- R2: The slave acknowledges the slave byte only when its bits 7..4 equal 4'b1010. After a mismatch it acknowledges nothing until the next START.
- R3: In a write (slave byte bit 0 = 0), slave byte bits 3..1 become address bits 10..8. The next byte becomes address bits 7..0. The slave acknowledges both bytes.
- R4: The slave acknowledges every data byte of a write. After each one, only address bits 3..0 increment, and they wrap inside the 16-byte page. A later byte that lands on the same offset replaces the earlier one.
- R5: Buffered bytes reach memory only on a STOP that follows at least one acknowledged data byte at a byte boundary. A write with no data byte starts no write cycle.
- R6: After a committing STOP, the write cycle lasts exactly `WR_CYCLES` clocks. During it the slave does not acknowledge its slave byte, and afterwards it does.
- R7: While `wp_i` is high, the slave acknowledges the slave byte and the word address, does not acknowledge the first data byte, and leaves memory unchanged. No write cycle starts.
- R8: A read (slave byte bit 0 = 1) sends the byte at the address counter. After every byte sent, the counter increments across all 11 bits and wraps from 2047 to 0. After a write, the counter holds the address that follows the last written byte, taken within its page.
- R9: A write of the slave byte and word address, followed by a repeated START and a read slave byte, reads from that word address.
- R10: When the host acknowledges a read byte, the slave sends the next byte. When the host does not acknowledge, the slave releases the data line and drives nothing until the next START.
- R11: While `inhibit_i` is high, the slave acknowledges no byte.
- R12: Read data goes out MSB first. The slave changes its data drive only after a detected falling clock edge, START or STOP, so the line is stable while the clock is high.
- R13: After reset the data line is released, no write cycle is running and the address counter is 0. Memory contents survive the reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| wp_i | input | 1 | Write protect; data bytes are refused while high |
| inhibit_i | input | 1 | Reset inhibit; no acknowledge while high |
| sda_oe_o | output | 1 | 1 pulls the data line low, 0 releases it |

## Verification
The bench builds the block with `WR_CYCLES` = 600. That is longer than one slave byte on the bench bus, so a poll sent right after a STOP lands inside the write cycle and is refused, and a poll sent after the wait is accepted. The 16-entry drain also fits inside the cycle. The address width keeps its default of 11, so the bench can reach the 2047-to-0 wrap of a sequential read and the in-page wrap of a 20-byte page write.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_RX, S_ACK, S_TX, S_MACK, S_WAIT
  } slv_state_e;

  typedef enum logic [1:0] {
    K_DEV, K_ADDR, K_DATA, K_READ
  } byte_kind_e;
endpackage

// File: rtl/i2c_line_mon.sv
module i2c_line_mon #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int MSB = SYNC_STAGES - 1;

  logic [MSB:0] scl_pipe, sda_pipe;
  logic         scl_q, sda_q;

  generate
    if (SYNC_STAGES > 1) begin : g_multi
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= {scl_pipe[MSB-1:0], scl_i};
          sda_pipe <= {sda_pipe[MSB-1:0], sda_i};
        end
      end
    end else begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= scl_i;
          sda_pipe <= sda_i;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_pipe[MSB];
      sda_q <= sda_pipe[MSB];
    end
  end

  assign sda_o      = sda_pipe[MSB];
  assign scl_rise_o = scl_pipe[MSB] & ~scl_q;
  assign scl_fall_o = ~scl_pipe[MSB] & scl_q;
  assign start_o    = scl_pipe[MSB] & scl_q & sda_q & ~sda_pipe[MSB];
  assign stop_o     = scl_pipe[MSB] & scl_q & ~sda_q & sda_pipe[MSB];
endmodule

// File: rtl/eeprom_array.sv
module eeprom_array #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) cells[waddr_i] <= wdata_i;
  end

  assign rdata_o = cells[raddr_i];
endmodule

// File: rtl/page_commit.sv
module page_commit #(
  parameter int ADDR_W    = 11,
  parameter int PAGE_W    = 4,
  parameter int DATA_W    = 8,
  parameter int WR_CYCLES = 1000000
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     clear_i,
  input  logic                     load_i,
  input  logic [PAGE_W-1:0]        load_off_i,
  input  logic [DATA_W-1:0]        load_data_i,
  input  logic                     commit_i,
  input  logic [ADDR_W-PAGE_W-1:0] commit_page_i,
  output logic                     busy_o,
  output logic                     mem_we_o,
  output logic [ADDR_W-1:0]        mem_waddr_o,
  output logic [DATA_W-1:0]        mem_wdata_o
);
  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int CNT_W      = $clog2(WR_CYCLES + 1);

  logic [DATA_W-1:0]        page_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0]    valid_q;
  logic [ADDR_W-PAGE_W-1:0] base_q;
  logic                     busy_q;
  logic [CNT_W-1:0]         cnt_q;
  logic [PAGE_W:0]          drain_q;
  logic [PAGE_W-1:0]        drain_idx;

  assign drain_idx = drain_q[PAGE_W-1:0];

  always_ff @(posedge clk_i) begin
    if (!busy_q && load_i) page_q[load_off_i] <= load_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      base_q  <= '0;
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      drain_q <= '0;
    end else if (busy_q) begin
      if (!drain_q[PAGE_W]) drain_q <= drain_q + 1'b1;
      if (cnt_q == CNT_W'(WR_CYCLES - 1)) begin
        busy_q  <= 1'b0;
        valid_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      if (clear_i) valid_q <= '0;
      if (load_i) valid_q[load_off_i] <= 1'b1;
      if (commit_i) begin
        busy_q  <= 1'b1;
        cnt_q   <= '0;
        drain_q <= '0;
        base_q  <= commit_page_i;
      end
    end
  end

  // one buffered byte per clock while the write cycle runs
  assign mem_we_o    = busy_q & ~drain_q[PAGE_W] & valid_q[drain_idx];
  assign mem_waddr_o = {base_q, drain_idx};
  assign mem_wdata_o = page_q[drain_idx];
  assign busy_o      = busy_q;
endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave #(
  parameter int         ADDR_W      = 11,
  parameter int         PAGE_W      = 4,
  parameter int         WR_CYCLES   = 1000000,
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] DEV_CODE    = 4'b1010
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  input  logic wp_i,
  input  logic inhibit_i,
  output logic sda_oe_o
);
  import eeprom_pkg::*;

  localparam int DATA_W = 8;
  localparam int HI_W   = ADDR_W - DATA_W;

  logic sda_s, scl_rise, scl_fall, start_evt, stop_evt;

  slv_state_e        state_q;
  byte_kind_e        kind_q;
  logic [3:0]        bit_cnt_q;
  logic [7:0]        sh_q, tx_q;
  logic              oe_q, mack_q, data_seen_q;
  logic [ADDR_W-1:0] ptr_q;
  logic [HI_W-1:0]   hi_q;

  logic              busy, mem_we, dec_pt, load, commit;
  logic [ADDR_W-1:0] mem_waddr;
  logic [7:0]        mem_wdata, rd_data;

  i2c_line_mon #(.SYNC_STAGES(SYNC_STAGES)) i_line_mon (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_evt),
    .stop_o     (stop_evt)
  );

  assign dec_pt = scl_fall && state_q == S_RX && bit_cnt_q == 4'd8;
  assign load   = dec_pt && kind_q == K_DATA && !wp_i && !inhibit_i;
  // STOP right after an acknowledged data byte: at most one SCL rise of the STOP itself
  assign commit = stop_evt && state_q == S_RX && kind_q == K_DATA
                  && bit_cnt_q <= 4'd1 && data_seen_q;

  page_commit #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W), .WR_CYCLES(WR_CYCLES)
  ) i_page_commit (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .clear_i       (start_evt),
    .load_i        (load),
    .load_off_i    (ptr_q[PAGE_W-1:0]),
    .load_data_i   (sh_q),
    .commit_i      (commit),
    .commit_page_i (ptr_q[ADDR_W-1:PAGE_W]),
    .busy_o        (busy),
    .mem_we_o      (mem_we),
    .mem_waddr_o   (mem_waddr),
    .mem_wdata_o   (mem_wdata)
  );

  eeprom_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_array (
    .clk_i   (clk_i),
    .we_i    (mem_we),
    .waddr_i (mem_waddr),
    .wdata_i (mem_wdata),
    .raddr_i (ptr_q),
    .rdata_o (rd_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      kind_q      <= K_DEV;
      bit_cnt_q   <= '0;
      sh_q        <= '0;
      tx_q        <= '0;
      oe_q        <= 1'b0;
      mack_q      <= 1'b0;
      data_seen_q <= 1'b0;
      ptr_q       <= '0;
      hi_q        <= '0;
    end else if (start_evt) begin
      state_q     <= S_RX;
      kind_q      <= K_DEV;
      bit_cnt_q   <= '0;
      oe_q        <= 1'b0;
      data_seen_q <= 1'b0;
    end else if (stop_evt) begin
      state_q <= S_IDLE;
      oe_q    <= 1'b0;
    end else begin
      unique case (state_q)
        S_RX: begin
          if (scl_rise) begin
            sh_q      <= {sh_q[6:0], sda_s};
            bit_cnt_q <= bit_cnt_q + 1'b1;
          end else if (dec_pt) begin
            state_q <= S_WAIT;
            unique case (kind_q)
              K_DEV: if (sh_q[7:4] == DEV_CODE && !busy && !inhibit_i) begin
                oe_q    <= 1'b1;
                state_q <= S_ACK;
                hi_q    <= sh_q[3:1];
                kind_q  <= sh_q[0] ? K_READ : K_ADDR;
              end
              K_ADDR: if (!inhibit_i) begin
                oe_q    <= 1'b1;
                state_q <= S_ACK;
                ptr_q   <= {hi_q, sh_q};
                kind_q  <= K_DATA;
              end
              K_DATA: if (load) begin
                oe_q        <= 1'b1;
                state_q     <= S_ACK;
                data_seen_q <= 1'b1;
                ptr_q       <= {ptr_q[ADDR_W-1:PAGE_W], ptr_q[PAGE_W-1:0] + 1'b1};
              end
              default: ;
            endcase
          end
        end
        S_ACK: if (scl_fall) begin
          bit_cnt_q <= '0;
          if (kind_q == K_READ) begin
            tx_q    <= rd_data;
            oe_q    <= ~rd_data[7];
            ptr_q   <= ptr_q + 1'b1;
            state_q <= S_TX;
          end else begin
            oe_q    <= 1'b0;
            state_q <= S_RX;
          end
        end
        S_TX: if (scl_fall) begin
          if (bit_cnt_q == 4'd7) begin
            oe_q    <= 1'b0;
            state_q <= S_MACK;
          end else begin
            tx_q      <= {tx_q[6:0], 1'b0};
            oe_q      <= ~tx_q[6];
            bit_cnt_q <= bit_cnt_q + 1'b1;
          end
        end
        S_MACK: begin
          if (scl_rise) mack_q <= ~sda_s;
          else if (scl_fall) begin
            if (mack_q) begin
              tx_q      <= rd_data;
              oe_q      <= ~rd_data[7];
              ptr_q     <= ptr_q + 1'b1;
              bit_cnt_q <= '0;
              state_q   <= S_TX;
            end else begin
              state_q <= S_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe_o = oe_q;
endmodule

// File: rtl/eeprom_checker.sv
module eeprom_checker #(
  parameter int ADDR_W    = 11,
  parameter int PAGE_W    = 4,
  parameter int WR_CYCLES = 1000000
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   sda_oe_o,
  input logic                   wp_i,
  input logic                   inhibit_i,
  input logic                   scl_fall,
  input logic                   start_evt,
  input logic                   stop_evt,
  input eeprom_pkg::slv_state_e state_q,
  input eeprom_pkg::byte_kind_e kind_q,
  input logic [3:0]             bit_cnt_q,
  input logic [ADDR_W-1:0]      ptr_q,
  input logic                   busy
);
  import eeprom_pkg::*;

  int unsigned busy_len;
  logic        at_dec;

  assign at_dec = scl_fall && state_q == S_RX && bit_cnt_q == 4'd8;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   busy_len <= 0;
    else if (busy) busy_len <= busy_len + 1;
    else           busy_len <= 0;
  end

  AST_OE_ONLY_AFTER_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> $past(scl_fall || start_evt || stop_evt)); // R12

  AST_BUSY_REFUSES_DEV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (at_dec && kind_q == K_DEV && busy) |=> !sda_oe_o); // R6

  AST_BUSY_LENGTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy) |-> busy_len == WR_CYCLES); // R6

  AST_BUSY_FROM_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(stop_evt)); // R5

  AST_INHIBIT_NO_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (at_dec && inhibit_i) |=> !sda_oe_o); // R11

  AST_WP_DATA_NACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (at_dec && kind_q == K_DATA && wp_i) |=> !sda_oe_o); // R7

  AST_PAGE_HIGH_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_RX && kind_q == K_DATA)
      |=> ptr_q[ADDR_W-1:PAGE_W] == $past(ptr_q[ADDR_W-1:PAGE_W])); // R4
endmodule

bind i2c_eeprom_slave eeprom_checker #(
  .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WR_CYCLES(WR_CYCLES)
) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sda_oe_o  (sda_oe_o),
  .wp_i      (wp_i),
  .inhibit_i (inhibit_i),
  .scl_fall  (scl_fall),
  .start_evt (start_evt),
  .stop_evt  (stop_evt),
  .state_q   (state_q),
  .kind_q    (kind_q),
  .bit_cnt_q (bit_cnt_q),
  .ptr_q     (ptr_q),
  .busy      (busy)
);

// File: tb/test_i2c_eeprom_slave.sv
module test_i2c_eeprom_slave;
  localparam int WR_CYC = 600;
  localparam int Q      = 8;
  localparam int DEPTH  = 2048;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, sda_drv = 1'b1, wp = 1'b0, inh = 1'b0;
  logic sda_oe;
  logic sda_line;

  int    errors = 0, checks = 0;
  bit    done = 1'b0;
  bit    quiet_exp = 1'b0;
  string quiet_req = "";

  logic [7:0] exp_mem [DEPTH];
  int         exp_ptr = 0;

  assign sda_line = sda_drv & ~sda_oe;

  always #2 clk = ~clk;

  i2c_eeprom_slave #(.WR_CYCLES(WR_CYC)) i_i2c_eeprom_slave (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .scl_i     (scl),
    .sda_i     (sda_line),
    .wp_i      (wp),
    .inhibit_i (inh),
    .sda_oe_o  (sda_oe)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // slave must stay silent in these windows
  always @(negedge clk) begin
    if (quiet_exp && !done) begin
      checks++;
      if (sda_oe !== 1'b0) begin
        errors++;
        $display("FAIL %s: actual sda_oe %0b expected 0", quiet_req, sda_oe);
      end
    end
  end

  task automatic qwait(input int n = 1);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_drv = 1'b1; qwait(); scl = 1'b1; qwait();
    sda_drv = 1'b0; qwait(); scl = 1'b0; qwait();
  endtask

  task automatic bus_stop();
    sda_drv = 1'b0; qwait(); scl = 1'b1; qwait();
    sda_drv = 1'b1; qwait(2);
  endtask

  task automatic send_bit(input logic b);
    sda_drv = b; qwait(); scl = 1'b1; qwait(2); scl = 1'b0; qwait();
  endtask

  task automatic put_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_drv = 1'b1; qwait(); scl = 1'b1; qwait();
    acked = sda_oe; qwait(); scl = 1'b0; qwait();
  endtask

  task automatic get_byte(input logic give_ack, output logic [7:0] b);
    logic s1;
    sda_drv = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      qwait(); scl = 1'b1; qwait();
      s1 = sda_line; qwait();
      chk("R12 data stable while clock high", sda_line, s1);
      b[i] = s1; scl = 1'b0; qwait();
    end
    send_bit(!give_ack);
    sda_drv = 1'b1;
  endtask

  task automatic dev_poll(input logic exp_ack, input string req);
    logic a;
    bus_start(); put_byte(8'hA0, a); chk(req, a, exp_ack); bus_stop();
  endtask

  task automatic wr_bytes(input int addr, input logic [7:0] d[$]);
    logic a;
    int   base, off;
    base = addr & ~15;
    off  = addr & 15;
    bus_start();
    put_byte({4'b1010, 3'(addr >> 8), 1'b0}, a); chk("R3 slave byte ack", a, 1);
    put_byte(8'(addr), a);                        chk("R3 word address ack", a, 1);
    foreach (d[i]) begin
      put_byte(d[i], a); chk("R4 data byte ack", a, 1);
      exp_mem[base + ((off + i) & 15)] = d[i];
    end
    exp_ptr = base + ((off + d.size()) & 15);
    bus_stop();
  endtask

  task automatic set_ptr(input int addr);
    logic a;
    bus_start();
    put_byte({4'b1010, 3'(addr >> 8), 1'b0}, a); chk("R9 dummy slave byte ack", a, 1);
    put_byte(8'(addr), a);                        chk("R9 dummy address ack", a, 1);
    exp_ptr = addr;
  endtask

  task automatic rd_seq(input int n, input string req);
    logic       a;
    logic [7:0] b;
    bus_start();
    put_byte({4'b1010, 3'(exp_ptr >> 8), 1'b1}, a); chk("R8 read slave byte ack", a, 1);
    for (int i = 0; i < n; i++) begin
      get_byte(i < n - 1, b);
      chk(req, b, exp_mem[exp_ptr]);
      exp_ptr = (exp_ptr + 1) % DEPTH;
    end
    quiet_req = "R10 released after host NACK"; quiet_exp = 1'b1;
    qwait(2);
    quiet_exp = 1'b0;
    bus_stop();
  endtask

  initial begin
    logic [7:0] q[$];
    logic       a;

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R13 reset releases data line", sda_oe, 0);

    // page write of 20 bytes from offset 0xC: wraps inside the page
    q = {};
    for (int i = 0; i < 20; i++) q.push_back(8'(8'h40 + i));
    wr_bytes(12'h12C, q);
    dev_poll(1'b0, "R6 slave byte refused during write cycle");
    qwait(WR_CYC / Q + 2);
    dev_poll(1'b1, "R6 slave byte accepted after write cycle");

    set_ptr(12'h120);
    rd_seq(15, "R4 page wrap contents via random read R9");
    rd_seq(1, "R8 current address read");

    // sequential read across the top of the address range
    q = {8'hC3}; wr_bytes(12'h7FF, q); qwait(WR_CYC / Q + 2);
    q = {8'h3C}; wr_bytes(12'h000, q); qwait(WR_CYC / Q + 2);
    set_ptr(12'h7FF);
    rd_seq(2, "R8 sequential wrap 2047 to 0 R10");

    // write protect
    wp = 1'b1;
    bus_start();
    put_byte(8'hA2, a); chk("R7 slave byte acked under protect", a, 1);
    put_byte(8'h25, a); chk("R7 word address acked under protect", a, 1);
    put_byte(8'hEE, a); chk("R7 first data byte refused", a, 0);
    bus_stop();
    wp = 1'b0;
    dev_poll(1'b1, "R7 no write cycle after protected write");
    set_ptr(12'h125);
    rd_seq(1, "R7 protected byte unchanged");

    // dummy write closed by STOP
    set_ptr(12'h005);
    bus_stop();
    dev_poll(1'b1, "R5 dummy write starts no write cycle");

    // STOP in the middle of a data byte
    set_ptr(12'h126);
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    bus_stop();
    dev_poll(1'b1, "R1 aborted write starts no write cycle");
    set_ptr(12'h126);
    rd_seq(1, "R1 aborted write leaves byte");

    // wrong device code, then silence until the next START
    bus_start();
    put_byte(8'hB0, a); chk("R2 wrong code refused", a, 0);
    quiet_req = "R2 silent after mismatch"; quiet_exp = 1'b1;
    put_byte(8'hA0, a);
    quiet_exp = 1'b0;
    chk("R2 later byte ignored until START", a, 0);
    bus_stop();

    // reset inhibit
    inh = 1'b1;
    dev_poll(1'b0, "R11 no ack while inhibited");
    inh = 1'b0;
    dev_poll(1'b1, "R11 ack returns after inhibit");

    // second reset: counter back to 0, memory kept
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R13 data line released after reset", sda_oe, 0);
    exp_ptr = 0;
    rd_seq(1, "R13 counter 0 after reset");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule